// File: doc/BRIEF.md
# Per-Lane Vector Memory Request Issuer

This block turns one vector memory instruction into a stream of per-lane memory requests. At acceptance it captures the operation, the number of dwords per lane, the execution mask and one address per lane. It then walks the mask from the lowest lane upward and emits one request for each active lane. Each request carries the lane index, that lane's address and the index of the lane's slot in the shared data buffer.

Every accepted lane is recorded in an outstanding-status vector that is loaded from the execution mask. Responses name a lane and clear its bit. When nothing is left to issue and no lane is outstanding, the block pulses `done` for one cycle and becomes free to accept the next instruction.

Multi-dword reads and writes place lane L's data at slot L*N. Atomics address their operand, compare value and return value at slot L. A fence ignores the mask and issues exactly one request that belongs to no lane. It finishes when its own response returns.

Top module: `vmem_lane_issuer`

## Requirements
- R1: After reset `in_ready` is 1, and `req_valid` and `done` are 0.
- R2: On acceptance of a non-fence instruction, the status vector is loaded with `in_mask`. Exactly one request is issued for each set mask bit, and none for a clear bit.
- R3: Requests leave in ascending lane order, at most one per cycle, advancing only on a cycle with `req_valid` and `req_ready` both high. While stalled, lane, address and slot hold steady.
- R4: `in_op` encoding is 0 read, 1 write, 2 atomic, 3 fence, and `req_op` repeats it. For reads and writes, `req_slot` equals lane × `in_ndw`, where `in_ndw` ranges from 1 to MAX_NDW.
- R5: For an atomic, `req_slot` equals the lane index, whatever `in_ndw` is. The operand, compare and return data of that lane share this index.
- R6: A fence issues exactly one request with `req_op`=3, `req_lane`=0 and `req_slot`=0, whatever the mask. `done` follows only after a response with `rsp_fence`=1.
- R7: A response with `rsp_fence`=0 clears status bit `rsp_lane`. `done` is high for exactly one cycle, in the cycle after the last outstanding bit has cleared.
- R8: An all-zero mask issues no request, and `done` is high in the first cycle after acceptance.
- R9: `in_ready` is 0 from acceptance until the cycle after `done`. `in_valid` during that time has no effect on the requests.
- R10: `req_addr` is the lane's address, bits [L*AW +: AW] of `in_addr`, captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken on valid |
| in_op | input | 2 | 0 read, 1 write, 2 atomic, 3 fence |
| in_ndw | input | NW | Dwords per lane (1..MAX_NDW) |
| in_mask | input | LANES | Execution mask |
| in_addr | input | LANES*AW | Per-lane addresses, lane L at [L*AW +: AW] |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side takes the request |
| req_op | output | 2 | Operation of the request |
| req_lane | output | LW | Lane index (0 for a fence) |
| req_addr | output | AW | Lane address |
| req_slot | output | LW+NW | Data buffer slot index |
| rsp_valid | input | 1 | Response present |
| rsp_fence | input | 1 | Response belongs to the fence |
| rsp_lane | input | LW | Lane the response completes |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check four things. A lane being requested is still marked outstanding. A stalled request holds steady, and lanes climb between requests. A fence carries lane 0 with an empty status vector, and `done` is a single-cycle pulse with nothing outstanding that reopens the input. Some properties only the bench scenarios can show: the exact lane sequence for a given mask, correct addresses and slot arithmetic per operation, the count of requests per instruction, the fence waiting on its response, and that an offer made while busy leaves no trace.

// File: rtl/vmem_lane_issuer.sv
module vmem_lane_issuer #(
  parameter int LANES   = 64,
  parameter int AW      = 32,
  parameter int MAX_NDW = 4,
  localparam int LW = $clog2(LANES),
  localparam int NW = $clog2(MAX_NDW + 1),
  localparam int SW = LW + NW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_op,
  input  logic [NW-1:0]         in_ndw,
  input  logic [LANES-1:0]      in_mask,
  input  logic [LANES*AW-1:0]   in_addr,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [1:0]            req_op,
  output logic [LW-1:0]         req_lane,
  output logic [AW-1:0]         req_addr,
  output logic [SW-1:0]         req_slot,
  input  logic                  rsp_valid,
  input  logic                  rsp_fence,
  input  logic [LW-1:0]         rsp_lane,
  output logic                  done
);
  localparam logic [1:0] OP_AT = 2'd2;
  localparam logic [1:0] OP_FN = 2'd3;

  logic                busy, fence_pend, fence_out;
  logic [1:0]          op_q;
  logic [NW-1:0]       ndw_q;
  logic [LANES-1:0]    pend, stat;
  logic [LANES*AW-1:0] addr_q;
  logic [LW-1:0]       sel;

  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend[i]) sel = LW'(i);
  end

  wire is_fence = (op_q == OP_FN);
  wire accept   = in_valid && in_ready;
  wire fire     = req_valid && req_ready;

  assign in_ready  = !busy;
  assign req_valid = busy && (is_fence ? fence_pend : |pend);
  assign req_op    = op_q;
  assign req_lane  = is_fence ? '0 : sel;
  assign req_addr  = is_fence ? '0 : addr_q[sel*AW +: AW];
  assign req_slot  = is_fence ? '0 :
                     (op_q == OP_AT) ? SW'(sel) : SW'(sel) * SW'(ndw_q);
  assign done      = busy && (pend == '0) && (stat == '0) && !fence_pend && !fence_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      fence_pend <= 1'b0;
      fence_out  <= 1'b0;
      op_q       <= '0;
      ndw_q      <= '0;
      pend       <= '0;
      stat       <= '0;
      addr_q     <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      op_q       <= in_op;
      ndw_q      <= in_ndw;
      addr_q     <= in_addr;
      fence_pend <= (in_op == OP_FN);
      fence_out  <= 1'b0;
      pend       <= (in_op == OP_FN) ? '0 : in_mask;
      stat       <= (in_op == OP_FN) ? '0 : in_mask;
    end else begin
      if (done) busy <= 1'b0;
      if (fire) begin
        if (is_fence) begin
          fence_pend <= 1'b0;
          fence_out  <= 1'b1;
        end else begin
          pend[sel] <= 1'b0;
        end
      end
      if (rsp_valid) begin
        if (rsp_fence) fence_out <= 1'b0;
        else           stat[rsp_lane] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vmem_lane_issuer_chk.sv
module vmem_lane_issuer_chk #(
  parameter int LANES = 64,
  parameter int AW    = 32,
  parameter int LW    = 6,
  parameter int SW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_op,
  input logic [LW-1:0]    req_lane,
  input logic [AW-1:0]    req_addr,
  input logic [SW-1:0]    req_slot,
  input logic [LANES-1:0] stat,
  input logic             done
);
  p_req_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd3) |-> stat[req_lane]);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_lane) && $stable(req_addr) && $stable(req_slot)));

  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op != 2'd3) |=> (!req_valid || req_lane > $past(req_lane)));

  p_fence_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |-> (req_lane == '0 && stat == '0));

  p_done_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stat == '0 && !req_valid));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready);

  p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);
endmodule

bind vmem_lane_issuer vmem_lane_issuer_chk #(.LANES(LANES), .AW(AW), .LW(LW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .req_valid(req_valid),
  .req_ready(req_ready), .req_op(req_op), .req_lane(req_lane),
  .req_addr(req_addr), .req_slot(req_slot), .stat(stat), .done(done)
);

// File: tb/sim_vmem_lane_issuer.sv
module sim_vmem_lane_issuer;
  localparam int LANES = 64, AW = 32, MAX_NDW = 4;
  localparam int LW = $clog2(LANES), NW = $clog2(MAX_NDW + 1), SW = LW + NW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, req_ready = 0, rsp_valid = 0, rsp_fence = 0;
  logic [1:0] in_op = 0;
  logic [NW-1:0] in_ndw = 0;
  logic [LANES-1:0] in_mask = 0;
  logic [LANES*AW-1:0] in_addr = 0;
  logic [LW-1:0] rsp_lane = 0;
  logic in_ready, req_valid, done;
  logic [1:0] req_op;
  logic [LW-1:0] req_lane;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_slot;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  vmem_lane_issuer #(.LANES(LANES), .AW(AW), .MAX_NDW(MAX_NDW)) u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic offer(input logic [1:0] op, input int ndw, input logic [LANES-1:0] mask, input logic [AW-1:0] base);
    in_valid = 1; in_op = op; in_ndw = NW'(ndw); in_mask = mask;
    for (int l = 0; l < LANES; l++) in_addr[l*AW +: AW] = base + AW'(l * 16);
    #1 chk(in_ready == 1, "R9 ready before offer", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run(input logic [1:0] op, input int ndw, input logic [LANES-1:0] mask, input bit stall, input logic [AW-1:0] base);
    logic [LANES-1:0] rem;
    int cyc, last;
    offer(op, ndw, mask, base);
    rem = mask; cyc = 0;
    while (rem != 0 && cyc < 400) begin
      int el;
      logic [SW-1:0] es;
      el = 0;
      for (int l = LANES - 1; l >= 0; l--) if (rem[l]) el = l;
      es = (op == 2'd2) ? SW'(el) : SW'(el * ndw);
      req_ready = stall ? cyc[0] : 1'b1;
      #1;
      chk(req_valid && req_lane == LW'(el), "R2 R3 lane order", {req_valid, req_lane}, {1'b1, LW'(el)});
      chk(req_addr == base + AW'(el * 16) && req_op == op, "R10 address/op", req_addr, base + AW'(el * 16));
      chk(req_slot == es, op == 2'd2 ? "R5 atomic slot" : "R4 slot lane*N", req_slot, es);
      if (cyc == 0) chk(in_ready == 0, "R9 busy closes input", in_ready, 0);
      if (req_ready) rem[el] = 0;
      @(negedge clk);
      cyc++;
    end
    req_ready = 0;
    #1 chk(req_valid == 0, "R2 no extra request", req_valid, 0);
    last = -1;
    for (int l = 0; l < LANES; l++) if (mask[l] && last < 0) last = l;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (mask[l]) begin
        rsp_valid = 1; rsp_lane = LW'(l);
        if (l == last) chk(done == 0, "R7 no done before last response", done, 0);
        @(negedge clk);
      end
    end
    rsp_valid = 0;
    #1 chk(done == 1, "R7 done after last response", done, 1);
    @(negedge clk);
    #1 chk(done == 0 && in_ready == 1, "R7 R9 done one cycle, input reopens", {done, in_ready}, 2'b01);
  endtask

  localparam int NV = 6;
  localparam logic [69:0] VEC [NV] = '{
    {2'd0, 3'd1, 1'b0, 64'h0000_0000_0000_0005},
    {2'd1, 3'd2, 1'b1, 64'h8000_0000_0000_0001},
    {2'd0, 3'd4, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd2, 3'd3, 1'b1, 64'h0F00_0000_00F0_0010},
    {2'd1, 3'd3, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA},
    {2'd0, 3'd1, 1'b1, 64'h0000_0100_0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1 chk(in_ready == 1 && req_valid == 0 && done == 0, "R1 reset state", {in_ready, req_valid, done}, 3'b100);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [69:0] e;
      e = VEC[v];
      run(e[69:68], int'(e[67:65]), e[63:0], e[64], 32'h1000_0000 + 32'(v) * 32'h1_0000);
    end

    offer(2'd0, 1, 64'h0, 32'h2000_0000);
    #1 chk(done == 1 && req_valid == 0, "R8 empty mask done at once", {done, req_valid}, 2'b10);
    @(negedge clk);
    #1 chk(in_ready == 1 && done == 0, "R8 input reopens", {in_ready, done}, 2'b10);
    @(negedge clk);

    offer(2'd3, 2, 64'h0000_0000_0000_00FF, 32'h3000_0000);
    req_ready = 1;
    #1 chk(req_valid && req_op == 2'd3 && req_lane == 0 && req_slot == 0, "R6 fence request", {req_valid, req_op, req_lane, req_slot}, {1'b1, 2'd3, LW'(0), SW'(0)});
    @(negedge clk);
    req_ready = 0;
    #1 chk(req_valid == 0 && done == 0, "R6 single fence, waits response", {req_valid, done}, 2'b00);
    @(negedge clk);
    #1 chk(done == 0, "R6 still waiting", done, 0);
    rsp_valid = 1; rsp_fence = 1;
    @(negedge clk);
    rsp_valid = 0; rsp_fence = 0;
    #1 chk(done == 1, "R6 done after fence response", done, 1);
    @(negedge clk);

    offer(2'd0, 1, 64'h3, 32'h4000_0000);
    in_valid = 1; in_op = 2'd1; in_mask = 64'hF0;
    req_ready = 0;
    repeat (3) @(negedge clk);
    #1 chk(in_ready == 0 && req_lane == 0 && req_op == 2'd0, "R9 offer while busy ignored", {in_ready, req_op, req_lane}, {1'b0, 2'd0, LW'(0)});
    in_valid = 0;
    req_ready = 1;
    #1 chk(req_valid && req_lane == 0, "R9 lane 0 kept", req_lane, 0);
    @(negedge clk);
    #1 chk(req_valid && req_lane == 1, "R9 lane 1 kept", req_lane, 1);
    @(negedge clk);
    #1 chk(req_valid == 0, "R9 no lane from ignored offer", req_valid, 0);
    req_ready = 0;
    rsp_valid = 1; rsp_lane = 1;
    @(negedge clk);
    rsp_lane = 0;
    @(negedge clk);
    rsp_valid = 0;
    #1 chk(done == 1, "R7 done after out-of-order responses", done, 1);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule